// File: doc/BRIEF.md
# Run-Time Adjustable Serial Delay Line

This block is a serial-in, serial-out shift chain of up to sixteen stages, shaped the way a single lookup-table memory would hold it. Each clock on which the enable is high moves every stored bit one position along the chain and takes a new bit in at the head. The stored data never moves in response to the depth input.

A 4-bit depth code chooses which stage feeds the output through a combinational selector. The delay from input to output is therefore the code plus one clock, anywhere from 1 to 16 cycles. Because the code only moves the output tap, the delay can be retuned at run time. After a change, the bits already stored become visible at their new positions at once.

The stages start at zero. A synchronous active-high reset also clears them, so a long delay line can be flushed without clocking zeros through it.

Top module: `addr_tap_srl`

## Requirements
- R1: When `rst` is high at a rising clock edge, every stage is cleared, and from then on `dout` reads 0 for every depth code until new ones are shifted in.
- R2: When `ce` is high and `rst` low at a rising edge, stage 0 takes `din` and each stage k (k of 1 or more) takes the value that stage k-1 held before the edge.
- R3: When `ce` is low and `rst` low at a rising edge, every stage keeps its value, so `dout` does not change while `depth` is held, whatever `din` does.
- R4: With `depth` held at code d, a bit driven on `din` appears on `dout` right after the (d+1)-th enabled rising edge, counting the edge that captures it.
- R5: `dout` always shows stage number `depth` (the code read as an unsigned binary number). A change of `depth` changes `dout` without any clock edge and leaves the stored data unchanged.
- R6: Code 0 gives a one-cycle delay (`dout` is the bit taken at the most recent enabled edge), and code 15 gives a sixteen-cycle delay (the oldest stage).
- R7: At power-up, before any clock edge, all stages hold 0, so `dout` is 0 for every depth code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear of all stages |
| ce | input | 1 | Shift enable; one position per enabled edge |
| din | input | DATA_W (1) | Serial data entering stage 0 |
| depth | input | SEL_W (4) | Output tap code; delay is code plus one |
| dout | output | DATA_W (1) | Data read combinationally from the chosen stage |

## Verification
Shift results fall due one rising edge after the enabled clock that takes the input. The bench's reference chain advances at the same edge and queues the expected output. A monitor takes the item off the queue one nanosecond after that edge, before the driver moves any input, so a bit entered with code d is compared just after its (d+1)-th enabled edge. Tap changes are due with no clock at all: the bench moves `depth` in the middle of a cycle and samples `dout` one nanosecond later, well before the next edge. Hold and reset checks use the same queue, because their results are also due at the edge that follows.

// File: rtl/srl_pkg.sv
package srl_pkg;

  // Largest chain one lookup-table memory element holds.
  localparam int unsigned SRL_STAGES_MAX = 16;

  // Width of a tap code able to address n stages (at least one bit).
  function automatic int tap_bits(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/srl_stage_chain.sv
module srl_stage_chain #(
  parameter int STAGES = 16,
  parameter int DATA_W = 1,
  localparam int FLAT_W = STAGES * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic [DATA_W-1:0] din,
  output logic [FLAT_W-1:0] taps_o
);

  logic [DATA_W-1:0] stage_q [STAGES];

  // Power-up contents: all zero.
  initial begin
    for (int i = 0; i < STAGES; i++) stage_q[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else if (ce) begin
      stage_q[0] <= din;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  for (genvar g = 0; g < STAGES; g++) begin : g_flat
    assign taps_o[g*DATA_W +: DATA_W] = stage_q[g];
  end

endmodule

// File: rtl/srl_tap_mux.sv
module srl_tap_mux #(
  parameter int STAGES = 16,
  parameter int DATA_W = 1,
  parameter int SEL_W  = 4,
  localparam int FLAT_W = STAGES * DATA_W
) (
  input  logic [FLAT_W-1:0] taps_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [DATA_W-1:0] data_o
);

  logic [STAGES-1:0] hit;
  logic [DATA_W-1:0] lane [STAGES];

  // One-hot decode of the tap code, then AND-OR reduction.
  for (genvar g = 0; g < STAGES; g++) begin : g_lane
    assign hit[g]  = (sel_i == SEL_W'(g));
    assign lane[g] = taps_i[g*DATA_W +: DATA_W] & {DATA_W{hit[g]}};
  end

  always_comb begin
    data_o = '0;
    for (int k = 0; k < STAGES; k++) data_o = data_o | lane[k];
  end

endmodule

// File: rtl/addr_tap_srl.sv
module addr_tap_srl
  import srl_pkg::*;
#(
  parameter int STAGES = SRL_STAGES_MAX,
  parameter int DATA_W = 1,
  parameter int SEL_W  = tap_bits(STAGES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic [DATA_W-1:0] din,
  input  logic [SEL_W-1:0]  depth,
  output logic [DATA_W-1:0] dout
);

  localparam int FLAT_W = STAGES * DATA_W;

  logic [FLAT_W-1:0] taps;

  srl_stage_chain #(
    .STAGES (STAGES),
    .DATA_W (DATA_W)
  ) chain_i (
    .clk    (clk),
    .rst    (rst),
    .ce     (ce),
    .din    (din),
    .taps_o (taps)
  );

  srl_tap_mux #(
    .STAGES (STAGES),
    .DATA_W (DATA_W),
    .SEL_W  (SEL_W)
  ) mux_i (
    .taps_i (taps),
    .sel_i  (depth),
    .data_o (dout)
  );

endmodule

// File: rtl/srl_chk.sv
module srl_chk #(
  parameter int STAGES = 16,
  parameter int DATA_W = 1,
  parameter int SEL_W  = 4,
  localparam int FLAT_W = STAGES * DATA_W
) (
  input logic              clk,
  input logic              rst,
  input logic              ce,
  input logic [DATA_W-1:0] din,
  input logic [SEL_W-1:0]  depth,
  input logic [DATA_W-1:0] dout,
  input logic [FLAT_W-1:0] taps
);

  logic rst_seen_q = 1'b0;

  always_ff @(posedge clk) rst_seen_q <= rst;

  // R1
  always_ff @(posedge clk) begin
    if (rst_seen_q) begin
      rst_clear_chk: assert (taps == '0);
    end
  end

  // R2
  head_take_chk: assert property (@(posedge clk) disable iff (rst)
    ce |=> taps[DATA_W-1:0] == $past(din));

  // R2
  chain_move_chk: assert property (@(posedge clk) disable iff (rst)
    ce |=> taps[FLAT_W-1:DATA_W] == $past(taps[FLAT_W-DATA_W-1:0]));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(taps));

  // R3
  idle_out_chk: assert property (@(posedge clk) disable iff (rst)
    !ce |=> (!$stable(depth) || $stable(dout)));

  // R6
  one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (ce && depth == '0) |=> (depth != '0 || dout == $past(din)));

endmodule

bind addr_tap_srl srl_chk #(
  .STAGES (STAGES),
  .DATA_W (DATA_W),
  .SEL_W  (SEL_W)
) chk_i (
  .clk   (clk),
  .rst   (rst),
  .ce    (ce),
  .din   (din),
  .depth (depth),
  .dout  (dout),
  .taps  (taps)
);

// File: tb/addr_tap_srl_tb_top.sv
`timescale 1ns/1ps
module addr_tap_srl_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ce  = 1'b0;
  logic [0:0] din = 1'b0;
  logic [3:0] depth = 4'd0;
  logic [0:0] dout;

  int checks = 0;
  int errors = 0;

  logic [15:0] model = 16'h0;
  bit          exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  addr_tap_srl dut_i (
    .clk   (clk),
    .rst   (rst),
    .ce    (ce),
    .din   (din),
    .depth (depth),
    .dout  (dout)
  );

  task automatic check_now(input bit expv, input string tag);
    checks++;
    if (dout[0] !== expv) begin
      errors++;
      $display("FAIL %s: dout=%b expected=%b depth=%0d t=%0t", tag, dout[0], expv, depth, $time);
    end
  endtask

  // Driver: called 2 ns after an edge; result due 1 ns after the next edge.
  task automatic cyc(input bit d, input bit e, input bit r, input logic [3:0] dep, input string tag);
    din = d; ce = e; rst = r; depth = dep;
    @(posedge clk);
    if (r) model = 16'h0;
    else if (e) model = {model[14:0], d};
    exp_q.push_back(model[dep]);
    tag_q.push_back(tag);
    #2;
  endtask

  // Monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        bit    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check_now(e, t);
      end
    end
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: expired, actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R7: before any edge
    #1;
    depth = 4'd0;  #0.1 check_now(1'b0, "R7");
    depth = 4'd15; #0.1 check_now(1'b0, "R7");
    depth = 4'd7;  #0.1 check_now(1'b0, "R7");
    @(posedge clk); #2;
    cyc(0, 0, 1, 4'd0, "R1");
    cyc(0, 0, 1, 4'd0, "R1");

    // R6: code 0, single pulse
    cyc(1, 1, 0, 4'd0, "R6");
    cyc(0, 1, 0, 4'd0, "R6");
    cyc(1, 1, 0, 4'd0, "R6");
    // R4: pulses at several depths
    for (int s = 0; s < 4; s++) begin
      logic [3:0] d;
      d = (s == 0) ? 4'd2 : (s == 1) ? 4'd7 : (s == 2) ? 4'd11 : 4'd15;
      for (int k = 0; k < 17; k++) cyc(0, 1, 0, d, "R4");
      cyc(1, 1, 0, d, "R4");
      for (int k = 0; k < 18; k++) cyc(0, 1, 0, d, "R4");
    end
    // R6: code 15 sixteen-cycle delay on a pattern
    for (int k = 0; k < 40; k++) cyc(((k * 7) % 5) > 2, 1, 0, 4'd15, "R6");

    // R3: enable low, din toggling
    for (int k = 0; k < 16; k++) cyc(k[0], 1, 0, 4'd5, "R2");
    for (int k = 0; k < 10; k++) cyc(~k[0], 0, 0, 4'd5, "R3");
    for (int k = 0; k < 10; k++) cyc(k[1], 0, 0, 4'd14, "R3");

    // R2: gappy enable stream
    for (int k = 0; k < 60; k++) cyc(((k * 13) % 7) > 3, (k % 3) != 0, 0, 4'd5, "R2");

    // R5: tap moves with no clock while idle
    for (int k = 0; k < 16; k++) cyc((k % 3) == 0, 1, 0, 4'd0, "R2");
    ce = 1'b0;
    for (int d = 0; d < 16; d++) begin
      @(posedge clk); #2;
      depth = 4'(d);
      #1 check_now(model[d], "R5");
    end
    // R5: stored data unchanged after sweep
    depth = 4'd9; #0.5 check_now(model[9], "R5");

    // R1: flush a full chain of ones
    for (int k = 0; k < 16; k++) cyc(1, 1, 0, 4'd15, "R2");
    cyc(1, 1, 1, 4'd15, "R1");
    for (int d = 0; d < 16; d++) begin
      depth = 4'(d);
      #0.1 check_now(1'b0, "R1");
    end
    cyc(0, 0, 0, 4'd3, "R1");

    @(posedge clk); #2;
    @(posedge clk); #2;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule